// File: doc/BRIEF.md
# Reference-Locked Sync Pulse Divider

This block takes a fast system clock and divides it into a slower reference clock, 10 cycles per reference period with a 5-high, 5-low duty. It also emits a sync strobe one fast cycle wide. The strobe always coincides with a rising edge of the reference. Its spacing is a programmable whole number of reference periods, from 1 to 255, so that with a 100 MHz fast clock the strobe rate is 10/n MHz.

Software or a neighbouring block writes a new divisor through a value bus and a one-cycle load strobe. The new value is staged and only takes over when the current strobe period ends, so no period is ever cut short. An asynchronous realign pin lets several units line up their strobes. A low-to-high change on that pin restarts the period count, and the first strobe of the new sequence lands on the next reference rising edge. All pins are plain control levels. There is no streaming data path, so no valid/ready handshake exists and there is nothing to back-pressure.

Top module: `ref_sync_divider`

## Requirements
- R1: `ref_clk_o` is high for 5 fast cycles and low for 5 fast cycles, repeating. Its first rising edge is at the first clock edge after reset is released, and it keeps running without interruption through loads and realigns.
- R2: `sync_pulse_o` is high for exactly one fast cycle. It is only ever high in the first cycle of a reference high phase.
- R3: With divisor n, consecutive strobes are exactly 10·n fast cycles apart. After reset n is 1, so a strobe comes on every reference rising edge, the first one in the first cycle after release.
- R4: A value presented with `div_load` high at a clock edge is staged. It becomes the active divisor at the first period boundary (the edge that starts a strobe) after that edge. A load taken at the boundary edge itself waits for the following boundary. If several loads are taken before a boundary, the last one wins.
- R5: A loaded value of 0 acts as a divisor of 1.
- R6: `restart_in` passes through two synchronizing flops. If it is first sampled high at clock edge k, the period count restarts so that a strobe is issued at the first reference rising edge that is at or after edge k+2. Later strobes follow every 10·n cycles from that strobe.
- R7: Holding `restart_in` high causes only one restart. A further restart needs the pin to go low and then high again.
- R8: A restart also makes any staged divisor active at once, starting from the restarted strobe.
- R9: Reset is synchronous and active high. It sets the divisor to 1, and both outputs are low during reset and in the cycle in which reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (10 cycles per reference period) |
| rst | input | 1 | Synchronous active-high reset |
| div_value | input | 8 | Divisor value n, reference periods per strobe |
| div_load | input | 1 | Stages `div_value` at this clock edge |
| restart_in | input | 1 | Asynchronous realign request, rising level restarts the period |
| ref_clk_o | output | 1 | Divided reference clock, 5 high / 5 low |
| sync_pulse_o | output | 1 | One-cycle strobe on selected reference rising edges |

## Verification
Both outputs come from registers. A rising reference edge and a strobe therefore show up in the fast cycle right after the edge that ends phase count 9. A load is visible only at the next period boundary. A restart needs two synchronizer edges plus a wait of up to 10 cycles for the reference wrap. The bench numbers every fast cycle from reset release and samples the outputs at the falling clock edge. It keeps a cycle-indexed record of the next expected strobe: when a strobe is due, it adds 10·n to that record; on a restart detected on the second-delayed pin history, it moves the record to the next wrap. Every sampled value is then compared with this arithmetic, and no fixed delay is assumed.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

  // Strobes the reference phase counter hands to the period controller.
  typedef struct packed {
    logic wrap;       // this cycle is the last one of a reference period
    logic high_next;  // reference output will be high next cycle
  } rsd_phase_t;

endpackage

// File: rtl/rsd_level_sync.sv
module rsd_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  // One extra flop past the synchronizer keeps the previous settled level.
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN_W-2:0], async_i};
  end

  generate
    if (STAGES >= 1) begin : g_edge
      assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
    end else begin : g_bad
      assign rise_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/rsd_ref_phase.sv
module rsd_ref_phase
  import rsd_pkg::*;
#(
  parameter int CYC_PER_REF = 10,
  parameter int REF_HIGH    = 5
) (
  input  logic       clk,
  input  logic       rst,
  output rsd_phase_t phase_o,
  output logic       ref_o
);
  localparam int PH_W = (CYC_PER_REF > 1) ? $clog2(CYC_PER_REF) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_PER_REF - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(REF_HIGH);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  always_comb begin
    ph_d              = (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
    phase_o.wrap      = (ph_q == PH_LAST);
    phase_o.high_next = (ph_d < PH_HIGH);
  end

  // Reset parks the count on the last phase so the first edge out of reset
  // is a reference rising edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_LAST;
      ref_o <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      ref_o <= phase_o.high_next;
    end
  end

endmodule

// File: rtl/rsd_period_ctrl.sv
module rsd_period_ctrl #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap_i,
  input  logic             rise_i,
  input  logic [DIV_W-1:0] div_value,
  input  logic             div_load,
  output logic             pulse_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] shadow_q;
  logic [DIV_W-1:0] n_q;
  logic [DIV_W-1:0] per_q;
  logic             pend_q;
  logic [DIV_W-1:0] load_val;
  logic             restart_now;
  logic             boundary;
  logic             realign;

  always_comb begin
    load_val    = (div_value == '0) ? ONE : div_value;
    restart_now = wrap_i & (rise_i | pend_q);
    boundary    = wrap_i & (per_q == n_q - ONE);
    realign     = restart_now | boundary;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= ONE;
      n_q      <= ONE;
      per_q    <= '0;
      pend_q   <= 1'b0;
      pulse_o  <= 1'b0;
    end else begin
      if (realign) begin
        per_q <= '0;
        n_q   <= shadow_q;
      end else if (wrap_i) begin
        per_q <= per_q + ONE;
      end
      pend_q  <= (pend_q | rise_i) & ~wrap_i;
      if (div_load) shadow_q <= load_val;
      pulse_o <= realign;
    end
  end

endmodule

// File: rtl/ref_sync_divider.sv
module ref_sync_divider
  import rsd_pkg::*;
#(
  parameter int CYC_PER_REF = 10,
  parameter int REF_HIGH    = 5,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_value,
  input  logic             div_load,
  input  logic             restart_in,
  output logic             ref_clk_o,
  output logic             sync_pulse_o
);
  rsd_phase_t phase;
  logic       rise;

  rsd_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (restart_in),
    .rise_o  (rise)
  );

  rsd_ref_phase #(.CYC_PER_REF(CYC_PER_REF), .REF_HIGH(REF_HIGH)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .phase_o (phase),
    .ref_o   (ref_clk_o)
  );

  rsd_period_ctrl #(.DIV_W(DIV_W)) u_period (
    .clk       (clk),
    .rst       (rst),
    .wrap_i    (phase.wrap),
    .rise_i    (rise),
    .div_value (div_value),
    .div_load  (div_load),
    .pulse_o   (sync_pulse_o)
  );

endmodule

// File: rtl/rsd_checker.sv
module rsd_checker #(
  parameter int CYC_PER_REF = 10,
  parameter int REF_HIGH    = 5
) (
  input logic clk,
  input logic rst,
  input logic ref_clk_o,
  input logic sync_pulse_o
);
  localparam logic [15:0] HI_N  = 16'(REF_HIGH);
  localparam logic [15:0] LO_N  = 16'(CYC_PER_REF - REF_HIGH);
  localparam logic [15:0] GAP_N = 16'(CYC_PER_REF);

  logic [15:0] hi_cnt_q, lo_cnt_q, gap_q;
  logic        seen_fall_q, seen_pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt_q     <= '0;
      lo_cnt_q     <= '0;
      gap_q        <= '0;
      seen_fall_q  <= 1'b0;
      seen_pulse_q <= 1'b0;
    end else begin
      hi_cnt_q <= ref_clk_o ? ((hi_cnt_q == 16'hFFFF) ? hi_cnt_q : hi_cnt_q + 16'd1) : '0;
      lo_cnt_q <= ref_clk_o ? '0 : ((lo_cnt_q == 16'hFFFF) ? lo_cnt_q : lo_cnt_q + 16'd1);
      if (ref_clk_o == 1'b0 && hi_cnt_q != '0) seen_fall_q <= 1'b1;
      if (sync_pulse_o) begin
        gap_q        <= 16'd1;
        seen_pulse_q <= 1'b1;
      end else if (gap_q < GAP_N) begin
        gap_q <= gap_q + 16'd1;
      end
    end
  end

  a_r1_high_len: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_clk_o) |-> hi_cnt_q == HI_N);

  a_r1_low_len: assert property (@(posedge clk) disable iff (rst)
    ($rose(ref_clk_o) && seen_fall_q) |-> lo_cnt_q == LO_N);

  a_r2_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
    sync_pulse_o |-> (ref_clk_o && !$past(ref_clk_o)));

  a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
    sync_pulse_o |=> !sync_pulse_o);

  a_r3_min_spacing: assert property (@(posedge clk) disable iff (rst)
    (sync_pulse_o && seen_pulse_q) |-> gap_q >= GAP_N);

  a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!ref_clk_o && !sync_pulse_o));

endmodule

bind ref_sync_divider rsd_checker #(
  .CYC_PER_REF (CYC_PER_REF),
  .REF_HIGH    (REF_HIGH)
) u_rsd_checker (
  .clk          (clk),
  .rst          (rst),
  .ref_clk_o    (ref_clk_o),
  .sync_pulse_o (sync_pulse_o)
);

// File: tb/test_ref_sync_divider.sv
module test_ref_sync_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] div_value = '0;
  logic       div_load = 1'b0;
  logic       restart_in = 1'b0;
  logic       ref_clk_o;
  logic       sync_pulse_o;

  always #10 clk = ~clk;

  ref_sync_divider #(
    .CYC_PER_REF (10),
    .REF_HIGH    (5),
    .DIV_W       (8),
    .SYNC_STAGES (2)
  ) i_ref_sync_divider (
    .clk          (clk),
    .rst          (rst),
    .div_value    (div_value),
    .div_load     (div_load),
    .restart_in   (restart_in),
    .ref_clk_o    (ref_clk_o),
    .sync_pulse_o (sync_pulse_o)
  );

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  // Arithmetic expectation: cycle index since release, next strobe cycle,
  // active and staged divisor, pending realign, pin history.
  int    c = 0;
  int    nxt = 1;
  int    ncur = 1;
  int    sh = 1;
  bit    pend = 1'b0;
  bit    h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;
  string tag = "R2";

  task automatic check(input bit got, input bit exp, input string req, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s cycle %0d actual=%0b expected=%0b", req, what, c, got, exp);
    end
  endtask

  // Called at a falling edge: check this cycle, drive it, advance the model.
  task automatic step(input bit ld, input int v, input bit pin);
    bit rise;
    check(ref_clk_o, (c >= 1) && (((c - 1) % 10) < 5), "R1", "ref");
    check(sync_pulse_o, c == nxt, tag, "pulse");
    div_load   = ld;
    div_value  = v[7:0];
    restart_in = pin;
    if (c == nxt) nxt = c + 10 * ncur;
    rise = h2 && !h3;
    if ((pend || rise) && (c % 10 == 0)) begin
      ncur = sh;
      nxt  = c + 1;
      pend = 1'b0;
    end else begin
      if (rise) pend = 1'b1;
      if (c + 1 == nxt) ncur = sh;
    end
    if (ld) sh = ((v % 256) == 0) ? 1 : (v % 256);
    h3 = h2;
    h2 = h1;
    h1 = pin;
    c++;
    @(negedge clk);
  endtask

  task automatic idle(input int k);
    repeat (k) step(1'b0, 0, 1'b0);
  endtask

  initial begin
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      check(ref_clk_o, 1'b0, "R9", "ref in reset");
      check(sync_pulse_o, 1'b0, "R9", "pulse in reset");
    end
    rst = 1'b0;

    // R2 and R3 with the reset divisor of 1
    tag = "R2";
    idle(35);

    // R3 / R4: sweep the divisor
    for (int n = 2; n <= 12; n++) begin
      tag = "R4";
      step(1'b1, n, 1'b0);
      idle(10 * n + 15);
      tag = "R3";
      idle(20 * n + 5);
    end

    // R4: load taken at the boundary edge waits one more period
    tag = "R4";
    while (c + 1 != nxt) step(1'b0, 0, 1'b0);
    step(1'b1, 3, 1'b0);
    idle(80);
    // R4: last of several loads wins
    step(1'b1, 5, 1'b0);
    step(1'b1, 2, 1'b0);
    idle(90);

    // R5: zero acts as one
    tag = "R5";
    step(1'b1, 0, 1'b0);
    idle(60);

    // R6: realign at every reference phase
    step(1'b1, 4, 1'b0);
    idle(50);
    tag = "R6";
    for (int off = 0; off < 10; off++) begin
      idle(off + 3);
      step(1'b0, 0, 1'b1);
      step(1'b0, 0, 1'b1);
      idle(70);
    end

    // R7: held pin gives a single realign
    step(1'b1, 3, 1'b0);
    idle(40);
    tag = "R7";
    repeat (150) step(1'b0, 0, 1'b1);
    idle(40);

    // R8: realign applies a staged divisor at once
    tag = "R8";
    step(1'b1, 5, 1'b0);
    idle(60);
    while (c != nxt) step(1'b0, 0, 1'b0);
    step(1'b1, 8, 1'b0);
    step(1'b0, 0, 1'b1);
    step(1'b0, 0, 1'b1);
    idle(200);

    // R3: largest divisor
    tag = "R3";
    step(1'b1, 255, 1'b0);
    idle(10 * 255 * 2 + 120);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog cycle %0d actual=hung expected=finished", c);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule